// File: doc/BRIEF.md
# Prioritized Peripheral Pin Multiplexer

This block decides, for every pin of an 8-bit port, which function owns the pin. It sets the pin's output value and output enable, and it reports a 3-bit code naming the owner. There are seven candidate sources: a two-wire serial unit, three CAN-type controllers (A, B and C) and three SPI units (0, 1 and 2). Each source presents an enable plus per-signal output data and output-enable vectors. When no enabled source claims a pin, the pin falls back to general-purpose I/O, driven from externally held data and direction bits.

Ownership is resolved by a fixed priority. The resolution is purely combinational from the enables and a 5-bit routing register, so a change of enable takes effect in the same cycle. The routing register moves CAN controller C between four pin pairs and moves each SPI unit between its default and alternate pin nibble. Each routing write becomes visible on the clock edge that samples it. Every source always receives the pad values of the pins it is currently mapped to, whether or not it won them. A source routed away from this port sees zeros.

Top module: `pm_pin_mux`

## Requirements
- R1: A pin that no enabled source claims shows function code 0 (general-purpose I/O), drives gpio_out for that pin and takes its output enable from gpio_dir.
- R2: A pin owned by a source drives that source's output bit and output-enable bit for the signal mapped to the pin. Function codes: 1 two-wire serial, 2 CAN B, 3 CAN A, 4 CAN C, 5 SPI0, 6 SPI1, 7 SPI2. The code appears on pin_fn[3p+2:3p] for pin p.
- R3: When the two-wire serial unit is enabled it owns pins 6 (signal 0, data) and 7 (signal 1, clock), ahead of every other source.
- R4: On pins 1:0, CAN B owns the pair whenever it is enabled. Otherwise CAN A wins over CAN C even when C is routed there. A CAN signal 0 (transmit) sits on the even pin of a pair and signal 1 (receive) on the odd pin.
- R5: The routing register holds SPI2 alternate in bit 4, SPI1 alternate in bit 3, SPI0 alternate in bit 2 and the CAN C pair select in bits 1:0. It resets to 0, and a write with route_we is used from the clock edge that samples it onward.
- R6: The CAN C pair select places C on pins 7:6 for value 0, on pins 1:0 for 1, on pins 3:2 for 2 and on pins 5:4 for 3.
- R7: SPI signal k sits on pin base+k. SPI0 uses base 0 when its bit is 0 and base 4 when it is 1. SPI1 uses base 4 when its bit is 0 and leaves this port when it is 1. SPI2 is off the port when its bit is 0 and uses base 0 when it is 1. Among SPI units the order is SPI0, then SPI1, then SPI2, and every SPI unit ranks below both the two-wire serial unit and the CAN controllers.
- R8: Every source's input vector carries pad_in at the pins it is mapped to, whether enabled, winning or losing. A source mapped off the port receives zeros.
- R9: A change of any enable changes ownership in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| route_we | input | 1 | Routing register write strobe |
| route_wdata | input | 5 | Routing register write value |
| pad_in | input | 8 | Values sensed at the pins |
| gpio_out | input | 8 | General-purpose output data |
| gpio_dir | input | 8 | General-purpose direction, 1 = output |
| i2c_en | input | 1 | Two-wire serial enable |
| i2c_do | input | 2 | Two-wire serial output data |
| i2c_oe | input | 2 | Two-wire serial output enables |
| i2c_di | output | 2 | Two-wire serial pin inputs |
| canb_en | input | 1 | CAN B enable |
| canb_do | input | 2 | CAN B output data |
| canb_oe | input | 2 | CAN B output enables |
| canb_di | output | 2 | CAN B pin inputs |
| cana_en | input | 1 | CAN A enable |
| cana_do | input | 2 | CAN A output data |
| cana_oe | input | 2 | CAN A output enables |
| cana_di | output | 2 | CAN A pin inputs |
| canc_en | input | 1 | CAN C enable |
| canc_do | input | 2 | CAN C output data |
| canc_oe | input | 2 | CAN C output enables |
| canc_di | output | 2 | CAN C pin inputs |
| spi0_en | input | 1 | SPI0 enable |
| spi0_do | input | 4 | SPI0 output data |
| spi0_oe | input | 4 | SPI0 output enables |
| spi0_di | output | 4 | SPI0 pin inputs |
| spi1_en | input | 1 | SPI1 enable |
| spi1_do | input | 4 | SPI1 output data |
| spi1_oe | input | 4 | SPI1 output enables |
| spi1_di | output | 4 | SPI1 pin inputs |
| spi2_en | input | 1 | SPI2 enable |
| spi2_do | input | 4 | SPI2 output data |
| spi2_oe | input | 4 | SPI2 output enables |
| spi2_di | output | 4 | SPI2 pin inputs |
| pin_out | output | 8 | Resolved pin output data |
| pin_oe | output | 8 | Resolved pin output enables |
| pin_fn | output | 24 | Owner code, 3 bits per pin |

## Verification
The bench targets three-way contention on pins 1:0, where a design that ranked CAN A over CAN B, or let a routed CAN C beat CAN A, would report the wrong owner code and drive the wrong transmit bit. It checks the one-edge latency of routing writes: a design that used route_wdata directly would move a CAN controller before the edge, and one that registered it twice would move it a cycle late. It also checks a writer held active during reset, and losing or disabled sources whose inputs a faulty design would gate with ownership. A full sweep over all enable and routing combinations then catches any misordered priority, such as SPI1 beating SPI0 on the upper nibble or the serial unit losing pins 7:6 to CAN C.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int NPINS   = 8;
    localparam int NSRC    = 7;
    localparam int MAXW    = 4;
    localparam int PW      = $clog2(NPINS);
    localparam int SIDX_W  = $clog2(MAXW);
    localparam int FN_W    = 3;

    // source index doubles as priority rank (lower index wins)
    localparam int S_I2C  = 0;
    localparam int S_CANB = 1;
    localparam int S_CANA = 2;
    localparam int S_CANC = 3;
    localparam int S_SPI0 = 4;
    localparam int S_SPI1 = 5;
    localparam int S_SPI2 = 6;

    typedef enum logic [FN_W-1:0] {
        FN_GPIO = 3'd0,
        FN_I2C  = 3'd1,
        FN_CANB = 3'd2,
        FN_CANA = 3'd3,
        FN_CANC = 3'd4,
        FN_SPI0 = 3'd5,
        FN_SPI1 = 3'd6,
        FN_SPI2 = 3'd7
    } pin_fn_e;

    typedef struct packed {
        logic       spi2_alt;
        logic       spi1_alt;
        logic       spi0_alt;
        logic [1:0] canc_sel;
    } route_t;

    localparam int ROUTE_W = $bits(route_t);

    typedef struct packed {
        logic          hit;
        logic [PW-1:0] base;
    } window_t;

    function automatic int src_width(int s);
        return (s >= S_SPI0) ? 4 : 2;
    endfunction

    function automatic pin_fn_e src_fn(int s);
        return pin_fn_e'(FN_W'(s + 1));
    endfunction

    // Where a source lands on the port for a given routing value
    function automatic window_t src_window(int s, route_t r);
        window_t w;
        w.hit  = 1'b1;
        w.base = '0;
        case (s)
            S_I2C:          w.base = PW'(6);
            S_CANB, S_CANA: w.base = PW'(0);
            S_CANC: begin
                case (r.canc_sel)
                    2'd0:    w.base = PW'(6);
                    2'd1:    w.base = PW'(0);
                    2'd2:    w.base = PW'(2);
                    default: w.base = PW'(4);
                endcase
            end
            S_SPI0: w.base = r.spi0_alt ? PW'(4) : PW'(0);
            S_SPI1: begin
                if (r.spi1_alt) w.hit  = 1'b0;
                else            w.base = PW'(4);
            end
            S_SPI2: begin
                if (r.spi2_alt) w.base = PW'(0);
                else            w.hit  = 1'b0;
            end
            default: w.hit = 1'b0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pm_route_reg.sv
module pm_route_reg
    import pm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [ROUTE_W-1:0] wdata,
    output route_t             route_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
        end else if (we) begin
            route_q <= route_t'(wdata);
        end
    end

endmodule

// File: rtl/pm_window.sv
module pm_window
    import pm_pkg::*;
#(
    parameter int SRC = 0
) (
    input  route_t            route,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  claim,
    output logic [MAXW-1:0]   in_vec,
    output logic [PW-1:0]     base
);

    localparam int WIDTH = src_width(SRC);

    window_t win;

    always_comb begin
        win    = src_window(SRC, route);
        base   = win.base;
        claim  = '0;
        in_vec = '0;
        if (win.hit) begin
            for (int k = 0; k < WIDTH; k++) begin
                claim[PW'(win.base + PW'(k))] = 1'b1;
                in_vec[k]                     = pad_in[PW'(win.base + PW'(k))];
            end
        end
    end

endmodule

// File: rtl/pm_pin_arb.sv
module pm_pin_arb
    import pm_pkg::*;
#(
    parameter int PIN = 0
) (
    input  logic [NSRC-1:0] req,
    input  logic [MAXW-1:0] src_out  [NSRC],
    input  logic [MAXW-1:0] src_oe   [NSRC],
    input  logic [PW-1:0]   src_base [NSRC],
    input  logic            gpio_out,
    input  logic            gpio_dir,
    output pin_fn_e         fn,
    output logic            out,
    output logic            oe
);

    logic              found;
    logic [SIDX_W-1:0] off;

    always_comb begin
        fn    = FN_GPIO;
        out   = gpio_out;
        oe    = gpio_dir;
        found = 1'b0;
        off   = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (req[s] && !found) begin
                found = 1'b1;
                fn    = src_fn(s);
                off   = SIDX_W'(PW'(PIN) - src_base[s]);
                out   = src_out[s][off];
                oe    = src_oe[s][off];
            end
        end
    end

endmodule

// File: rtl/pm_pin_mux.sv
module pm_pin_mux
    import pm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   route_we,
    input  logic [ROUTE_W-1:0]     route_wdata,
    input  logic [NPINS-1:0]       pad_in,
    input  logic [NPINS-1:0]       gpio_out,
    input  logic [NPINS-1:0]       gpio_dir,
    input  logic                   i2c_en,
    input  logic [1:0]             i2c_do,
    input  logic [1:0]             i2c_oe,
    output logic [1:0]             i2c_di,
    input  logic                   canb_en,
    input  logic [1:0]             canb_do,
    input  logic [1:0]             canb_oe,
    output logic [1:0]             canb_di,
    input  logic                   cana_en,
    input  logic [1:0]             cana_do,
    input  logic [1:0]             cana_oe,
    output logic [1:0]             cana_di,
    input  logic                   canc_en,
    input  logic [1:0]             canc_do,
    input  logic [1:0]             canc_oe,
    output logic [1:0]             canc_di,
    input  logic                   spi0_en,
    input  logic [3:0]             spi0_do,
    input  logic [3:0]             spi0_oe,
    output logic [3:0]             spi0_di,
    input  logic                   spi1_en,
    input  logic [3:0]             spi1_do,
    input  logic [3:0]             spi1_oe,
    output logic [3:0]             spi1_di,
    input  logic                   spi2_en,
    input  logic [3:0]             spi2_do,
    input  logic [3:0]             spi2_oe,
    output logic [3:0]             spi2_di,
    output logic [NPINS-1:0]       pin_out,
    output logic [NPINS-1:0]       pin_oe,
    output logic [NPINS*FN_W-1:0]  pin_fn
);

    route_t             route_q;
    logic [NSRC-1:0]    src_en;
    logic [MAXW-1:0]    src_out  [NSRC];
    logic [MAXW-1:0]    src_oe   [NSRC];
    logic [MAXW-1:0]    src_in   [NSRC];
    logic [PW-1:0]      src_base [NSRC];
    logic [NPINS-1:0]   src_claim[NSRC];
    logic [NSRC-1:0]    pin_req  [NPINS];
    pin_fn_e            pin_fn_a [NPINS];

    pm_route_reg u_route (
        .clk    (clk),
        .rst    (rst),
        .we     (route_we),
        .wdata  (route_wdata),
        .route_q(route_q)
    );

    // gather sources in priority order
    always_comb begin
        src_en = '0;
        src_en[S_I2C]  = i2c_en;
        src_en[S_CANB] = canb_en;
        src_en[S_CANA] = cana_en;
        src_en[S_CANC] = canc_en;
        src_en[S_SPI0] = spi0_en;
        src_en[S_SPI1] = spi1_en;
        src_en[S_SPI2] = spi2_en;

        src_out[S_I2C]  = {2'b00, i2c_do};
        src_out[S_CANB] = {2'b00, canb_do};
        src_out[S_CANA] = {2'b00, cana_do};
        src_out[S_CANC] = {2'b00, canc_do};
        src_out[S_SPI0] = spi0_do;
        src_out[S_SPI1] = spi1_do;
        src_out[S_SPI2] = spi2_do;

        src_oe[S_I2C]   = {2'b00, i2c_oe};
        src_oe[S_CANB]  = {2'b00, canb_oe};
        src_oe[S_CANA]  = {2'b00, cana_oe};
        src_oe[S_CANC]  = {2'b00, canc_oe};
        src_oe[S_SPI0]  = spi0_oe;
        src_oe[S_SPI1]  = spi1_oe;
        src_oe[S_SPI2]  = spi2_oe;
    end

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            pm_window #(.SRC(s)) u_win (
                .route (route_q),
                .pad_in(pad_in),
                .claim (src_claim[s]),
                .in_vec(src_in[s]),
                .base  (src_base[s])
            );
        end
    endgenerate

    // per-pin request vectors: enabled and mapped here
    always_comb begin
        for (int p = 0; p < NPINS; p++) begin
            for (int s = 0; s < NSRC; s++) begin
                pin_req[p][s] = src_en[s] & src_claim[s][p];
            end
        end
    end

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            pm_pin_arb #(.PIN(p)) u_arb (
                .req     (pin_req[p]),
                .src_out (src_out),
                .src_oe  (src_oe),
                .src_base(src_base),
                .gpio_out(gpio_out[p]),
                .gpio_dir(gpio_dir[p]),
                .fn      (pin_fn_a[p]),
                .out     (pin_out[p]),
                .oe      (pin_oe[p])
            );
            assign pin_fn[p*FN_W +: FN_W] = pin_fn_a[p];
        end
    endgenerate

    assign i2c_di  = src_in[S_I2C][1:0];
    assign canb_di = src_in[S_CANB][1:0];
    assign cana_di = src_in[S_CANA][1:0];
    assign canc_di = src_in[S_CANC][1:0];
    assign spi0_di = src_in[S_SPI0];
    assign spi1_di = src_in[S_SPI1];
    assign spi2_di = src_in[S_SPI2];

    // upper halves of the two-signal sources are padding
    logic unused_pad;
    assign unused_pad = ^{src_in[S_I2C][3:2], src_in[S_CANB][3:2],
                          src_in[S_CANA][3:2], src_in[S_CANC][3:2]};

endmodule

// File: rtl/pm_pin_mux_chk.sv
module pm_pin_mux_chk
    import pm_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  route_we,
    input logic [ROUTE_W-1:0]    route_wdata,
    input logic [ROUTE_W-1:0]    route_q,
    input logic [NPINS-1:0]      gpio_out,
    input logic [NPINS-1:0]      gpio_dir,
    input logic                  i2c_en,
    input logic                  canb_en,
    input logic                  cana_en,
    input logic                  spi1_en,
    input logic                  spi2_en,
    input logic [NPINS-1:0]      pin_out,
    input logic [NPINS-1:0]      pin_oe,
    input logic [NPINS*FN_W-1:0] pin_fn
);

    // R5
    route_write_chk: assert property (@(posedge clk) disable iff (rst)
        route_we |=> route_q == $past(route_wdata));

    // R5
    route_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !route_we |=> $stable(route_q));

    // R3
    serial_prec_chk: assert property (@(posedge clk) disable iff (rst)
        i2c_en |-> (pin_fn[23:21] == FN_I2C) && (pin_fn[20:18] == FN_I2C));

    // R4
    canb_first_chk: assert property (@(posedge clk) disable iff (rst)
        canb_en |-> (pin_fn[2:0] == FN_CANB) && (pin_fn[5:3] == FN_CANB));

    // R4
    cana_over_c_chk: assert property (@(posedge clk) disable iff (rst)
        (!canb_en && cana_en) |-> (pin_fn[2:0] == FN_CANA));

    // R2
    spi_owner_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        ((pin_fn[2:0] == FN_SPI2) |-> spi2_en) and ((pin_fn[23:21] == FN_SPI1) |-> spi1_en));

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_gpio
            // R1
            gpio_fallback_chk: assert property (@(posedge clk) disable iff (rst)
                (pin_fn[p*FN_W +: FN_W] == FN_GPIO) |->
                    (pin_out[p] == gpio_out[p]) && (pin_oe[p] == gpio_dir[p]));
        end
    endgenerate

endmodule

bind pm_pin_mux pm_pin_mux_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .route_we   (route_we),
    .route_wdata(route_wdata),
    .route_q    (route_q),
    .gpio_out   (gpio_out),
    .gpio_dir   (gpio_dir),
    .i2c_en     (i2c_en),
    .canb_en    (canb_en),
    .cana_en    (cana_en),
    .spi1_en    (spi1_en),
    .spi2_en    (spi2_en),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pin_fn     (pin_fn)
);

// File: tb/test_pm_pin_mux.sv
module test_pm_pin_mux;

    logic        clk = 1'b0;
    logic        rst;
    logic        route_we;
    logic [4:0]  route_wdata;
    logic [7:0]  pad_in, gpio_out, gpio_dir;
    logic        i2c_en, canb_en, cana_en, canc_en, spi0_en, spi1_en, spi2_en;
    logic [1:0]  i2c_do, i2c_oe, canb_do, canb_oe, cana_do, cana_oe, canc_do, canc_oe;
    logic [3:0]  spi0_do, spi0_oe, spi1_do, spi1_oe, spi2_do, spi2_oe;
    logic [1:0]  i2c_di, canb_di, cana_di, canc_di;
    logic [3:0]  spi0_di, spi1_di, spi2_di;
    logic [7:0]  pin_out, pin_oe;
    logic [23:0] pin_fn;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pm_pin_mux i_pm_pin_mux (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // enable vector order: [0]serial [1]canB [2]canA [3]canC [4]spi0 [5]spi1 [6]spi2
    task automatic set_en(input logic [6:0] e);
        {spi2_en, spi1_en, spi0_en, canc_en, cana_en, canb_en, i2c_en} = e;
    endtask

    task automatic write_route(input logic [4:0] v);
        @(negedge clk);
        route_we = 1'b1;
        route_wdata = v;
        @(negedge clk);
        route_we = 1'b0;
    endtask

    function automatic logic [2:0] fn_of(input int p);
        return pin_fn[3*p +: 3];
    endfunction

    // independent reference of the ownership rules
    function automatic void ref_pin(input int p, input logic [6:0] e, input logic [4:0] r,
                                    output logic [2:0] fn, output logic o, output logic oe);
        fn = 3'd0;
        if (p >= 6) begin
            if (e[0]) fn = 3'd1;
            else if (e[3] && r[1:0] == 2'd0) fn = 3'd4;
            else if (e[4] && r[2]) fn = 3'd5;
            else if (e[5] && !r[3]) fn = 3'd6;
        end else if (p >= 4) begin
            if (e[3] && r[1:0] == 2'd3) fn = 3'd4;
            else if (e[4] && r[2]) fn = 3'd5;
            else if (e[5] && !r[3]) fn = 3'd6;
        end else if (p >= 2) begin
            if (e[3] && r[1:0] == 2'd2) fn = 3'd4;
            else if (e[4] && !r[2]) fn = 3'd5;
            else if (e[6] && r[4]) fn = 3'd7;
        end else begin
            if (e[1]) fn = 3'd2;
            else if (e[2]) fn = 3'd3;
            else if (e[3] && r[1:0] == 2'd1) fn = 3'd4;
            else if (e[4] && !r[2]) fn = 3'd5;
            else if (e[6] && r[4]) fn = 3'd7;
        end
        case (fn)
            3'd1: begin o = i2c_do[p % 2];  oe = i2c_oe[p % 2];  end
            3'd2: begin o = canb_do[p % 2]; oe = canb_oe[p % 2]; end
            3'd3: begin o = cana_do[p % 2]; oe = cana_oe[p % 2]; end
            3'd4: begin o = canc_do[p % 2]; oe = canc_oe[p % 2]; end
            3'd5: begin o = spi0_do[p % 4]; oe = spi0_oe[p % 4]; end
            3'd6: begin o = spi1_do[p % 4]; oe = spi1_oe[p % 4]; end
            3'd7: begin o = spi2_do[p % 4]; oe = spi2_oe[p % 4]; end
            default: begin o = gpio_out[p]; oe = gpio_dir[p]; end
        endcase
    endfunction

    task automatic check_all_pins(input string req, input logic [6:0] e, input logic [4:0] r);
        logic [2:0] f;
        logic o, oe;
        for (int p = 0; p < 8; p++) begin
            ref_pin(p, e, r, f, o, oe);
            chk(req, {fn_of(p), pin_out[p], pin_oe[p]}, {f, o, oe});
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        route_we = 1'b1;          // write attempted during reset must be dropped
        route_wdata = 5'h1F;
        set_en(7'b0);
        repeat (3) @(negedge clk);
        route_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset: all pins general-purpose
        check_all_pins("R1 reset gpio", 7'b0, 5'd0);
        // R5 reset routing 0: CAN C appears on pins 7:6
        set_en(7'b0001000);
        #1;
        chk("R5 reset route canC pin7", fn_of(7), 3'd4);
        chk("R6 reset route canC pin0 free", fn_of(0), 3'd0);
        set_en(7'b0);
    endtask

    task automatic t_gpio;
        @(negedge clk);
        set_en(7'b0);
        gpio_out = 8'h3C; gpio_dir = 8'hA5;
        #1;
        chk("R1 gpio out", pin_out, 8'h3C);
        chk("R1 gpio oe", pin_oe, 8'hA5);
        gpio_out = 8'b1100_1010; gpio_dir = 8'b0110_0101;
        #1;
        chk("R1 gpio out pattern2", pin_out, 8'b1100_1010);
    endtask

    task automatic t_serial;
        @(negedge clk);
        set_en(7'b0011001);       // serial, canC (route 0 -> 7:6), spi0 alt? route=0 so low nibble
        #1;
        chk("R3 serial pin6", fn_of(6), 3'd1);
        chk("R3 serial pin7", fn_of(7), 3'd1);
        chk("R3 serial data on pin6", {pin_out[6], pin_oe[6]}, {i2c_do[0], i2c_oe[0]});
        chk("R2 spi0 pin3", fn_of(3), 3'd5);
        set_en(7'b0001000);       // R9 same-cycle: serial drops, canC takes 7:6
        #1;
        chk("R9 canC takes pins immediately", fn_of(7), 3'd4);
    endtask

    task automatic t_can_pair;
        write_route(5'b00001);    // canC on pins 1:0
        for (int e = 0; e < 8; e++) begin
            logic [2:0] exp;
            @(negedge clk);
            set_en({3'b000, e[2], e[1], e[0], 1'b0});  // bits: canB=e0, canA=e1, canC=e2
            #1;
            exp = e[0] ? 3'd2 : e[1] ? 3'd3 : e[2] ? 3'd4 : 3'd0;
            chk("R4 pair 1:0 owner", {fn_of(1), fn_of(0)}, {exp, exp});
        end
        set_en(7'b0);
    endtask

    task automatic t_route_latency;
        write_route(5'b00000);
        @(negedge clk);
        set_en(7'b0001000);
        route_we = 1'b1;
        route_wdata = 5'b00010;   // move canC to pins 3:2
        #1;
        chk("R5 before edge old place", fn_of(7), 3'd4);
        chk("R5 before edge new place free", fn_of(2), 3'd0);
        @(negedge clk);
        route_we = 1'b0;
        #1;
        chk("R6 after edge pins 3:2", {fn_of(3), fn_of(2)}, {3'd4, 3'd4});
        chk("R6 after edge pins 7:6 freed", fn_of(7), 3'd0);
        write_route(5'b00011);
        #1;
        chk("R6 route 3 pins 5:4", fn_of(4), 3'd4);
        set_en(7'b0);
    endtask

    task automatic t_inputs;
        pad_in = 8'b1011_0110;
        write_route(5'b00000);
        @(negedge clk);
        set_en(7'b1111111);
        #1;
        // R8 losers and winners see the pads they map to
        chk("R8 serial in", i2c_di, 2'b10);
        chk("R8 canA loser in", cana_di, 2'b10);
        chk("R8 canC loser in", canc_di, 2'b10);
        chk("R8 spi0 in", spi0_di, 4'b0110);
        chk("R8 spi1 loser in", spi1_di, 4'b1011);
        chk("R8 spi2 off port", spi2_di, 4'b0000);
        set_en(7'b0);
        #1;
        chk("R8 disabled canB still sees pads", canb_di, 2'b10);
        write_route(5'b11110);
        #1;
        chk("R7 spi0 alt in", spi0_di, 4'b1011);
        chk("R7 spi1 off port in", spi1_di, 4'b0000);
        chk("R7 spi2 alt in", spi2_di, 4'b0110);
        chk("R6 canC route2 in", canc_di, 2'b01);
    endtask

    task automatic t_spi_route;
        write_route(5'b00100);    // spi0 alt -> upper nibble, spi1 default upper
        @(negedge clk);
        set_en(7'b0110000);
        #1;
        chk("R7 spi0 beats spi1 pin5", fn_of(5), 3'd5);
        chk("R7 spi0 signal1 on pin5", pin_out[5], spi0_do[1]);
        chk("R7 low nibble gpio", fn_of(1), 3'd0);
        write_route(5'b10000);    // spi2 alt -> low nibble, contends with spi0 default
        @(negedge clk);
        set_en(7'b1010000);
        #1;
        chk("R7 spi0 beats spi2 pin0", fn_of(0), 3'd5);
        set_en(7'b1000000);
        #1;
        chk("R7 spi2 owns pin2", fn_of(2), 3'd7);
        chk("R7 spi2 signal2 on pin2", {pin_out[2], pin_oe[2]}, {spi2_do[2], spi2_oe[2]});
        set_en(7'b0);
    endtask

    task automatic t_sweep;
        for (int r = 0; r < 32; r++) begin
            write_route(5'(r));
            for (int e = 0; e < 128; e++) begin
                @(negedge clk);
                set_en(7'(e));
                #1;
                check_all_pins("R2 sweep", 7'(e), 5'(r));
            end
        end
        set_en(7'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        route_we = 1'b0;
        route_wdata = '0;
        pad_in = 8'b1011_0110;
        gpio_out = 8'b1100_1010; gpio_dir = 8'b0110_0101;
        i2c_do = 2'b01;  i2c_oe = 2'b10;
        canb_do = 2'b10; canb_oe = 2'b01;
        cana_do = 2'b01; cana_oe = 2'b11;
        canc_do = 2'b11; canc_oe = 2'b01;
        spi0_do = 4'b1010; spi0_oe = 4'b0110;
        spi1_do = 4'b0101; spi1_oe = 4'b1100;
        spi2_do = 4'b0011; spi2_oe = 4'b1001;
        set_en(7'b0);
        t_reset();
        t_gpio();
        t_serial();
        t_can_pair();
        t_route_latency();
        t_inputs();
        t_spi_route();
        t_sweep();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule